// File: doc/BRIEF.md
# Single-Precision Reciprocal Estimator

This block returns a fast approximation of 1/x for a 32-bit IEEE-754 single-precision operand. The approximation is accurate to about 8 bits. It is meant to seed an iterative refinement that runs elsewhere. One operand is accepted per clock under a valid strobe. Each result appears exactly two cycles later. Rounding mode, flush-to-zero and default-NaN control bits travel with the operand, and exception flags collect in a sticky register until a synchronous clear.

The mantissa of an operand forms a 9-bit index in 256..511. The index is a leading one followed by the top eight stored fraction bits. A constant table is built at elaboration from an exact integer rule: a = 2*index+1, b = floor(2^19/a), estimate = (b+1)>>1. The estimate always lies in 256..511. Its low eight bits form the top of the result fraction, with zeros below them. The result exponent is 253 minus the biased input exponent. Special operands, tiny inputs that would overflow, and large inputs that give subnormal results each follow their own rule.

Top module: `recip_est_unit`

## Requirements
- R1: For a finite normal input with biased exponent e and fraction f, and no flush, the result is {sign, 253-e, est[7:0], 15 zero bits}. Here est is the rule applied to index 256 + f[22:15]. For example, 1.0 (0x3F800000) gives 0x3F7F8000.
- R2: in_ready stays high after reset. An operand presented with in_valid at a rising edge produces out_valid and its result after the second rising edge. Operands may arrive on consecutive cycles, and results come out in the same order.
- R3: A NaN input gives the same word with fraction bit 22 set. The invalid flag (bit 0) is raised only when bit 22 of the input was clear. When dnan_en is high, the result is 0x7FC00000 instead.
- R4: An infinite input gives a zero with the same sign, and no flag is raised.
- R5: A zero input gives an infinity with the same sign and raises divide-by-zero (flag bit 1).
- R6: A nonzero input with exponent 0 and f[22:21] = 00 raises overflow (bit 2) and inexact (bit 4). rnd_mode encodes 0 = nearest, 1 = toward +inf, 2 = toward -inf, 3 = toward zero. The result is a signed infinity for mode 0, for mode 1 with a positive input, and for mode 2 with a negative input. In every other case it is the signed largest normal, magnitude 0x7F7FFFFF.
- R7: With ftz_en high, a biased exponent of 253 or 254 gives a signed zero and raises underflow (bit 3). With ftz_en low, exponent 253 gives exponent field 0 and fraction {1, est[7:0], 14 zeros}. Exponent 254 gives exponent field 0 and fraction {01, est[7:0], 13 zeros}.
- R8: With ftz_en low, a subnormal input with f[22] = 1 uses index bits f[21:14] and result exponent 253. A subnormal input with f[22] = 0 and f[21] = 1 uses f[20:13] and result exponent 254.
- R9: With ftz_en high, a subnormal input is treated as a zero of the same sign: the result is infinity and divide-by-zero is raised.
- R10: Flags (bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact) OR in when each result appears and never drop while flag_clr is low. A cycle with flag_clr high and no result completing leaves them all zero.
- R11: While reset is applied and after it, out_valid, out_res and flag_sticky are zero until a result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand strobe |
| in_ready | output | 1 | Operand may be accepted (held high) |
| in_op | input | 32 | Single-precision operand |
| rnd_mode | input | 2 | Rounding mode for tiny-input saturation |
| ftz_en | input | 1 | Flush subnormal inputs and subnormal results to zero |
| dnan_en | input | 1 | Return the default NaN for NaN inputs |
| flag_clr | input | 1 | Synchronous clear of the sticky flags |
| out_valid | output | 1 | Result strobe |
| out_res | output | 32 | Reciprocal estimate |
| flag_sticky | output | 5 | Sticky exception flags |

## Verification
The assertions take for granted that in_valid, in_op and the control bits are known and settled at every rising edge once reset has been released. They also take for granted that flag_clr is never high in the same cycle that a result completes, so the clear and set paths are checked separately. The stimulus changes inputs only on falling edges. It pulses flag_clr only in gaps where no operand is in flight. It drives in_valid low whenever it has no operand to present.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;

  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int IDX_W   = 8;
  localparam int EST_W   = IDX_W + 1;
  localparam int XEXP_W  = EXP_W + 2;
  localparam int FLAG_W  = 5;

  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int RBIAS   = 2 * ((1 << (EXP_W - 1)) - 1) - 1;

  localparam int FL_INV = 0;
  localparam int FL_DZ  = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;
  localparam int FL_INX = 4;

  typedef enum logic [2:0] {
    RK_EST,
    RK_QNAN,
    RK_DNAN,
    RK_ZERO,
    RK_INF,
    RK_MAXN
  } res_kind_e;

  typedef struct packed {
    res_kind_e                 kind;
    logic                      sign;
    logic signed [XEXP_W-1:0]  xexp;
    logic [IDX_W-1:0]          idx;
    logic [FLAG_W-1:0]         flags;
  } cls_t;

endpackage

// File: rtl/recip_est_rom.sv
module recip_est_rom #(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W:0]   est_o
);

  localparam int E_W     = IDX_W + 1;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int NUMER   = 1 << (2 * E_W + 1);

  function automatic logic [E_W-1:0] rule(input int unsigned idx);
    int unsigned a;
    int unsigned b;
    a = 2 * idx + 1;
    b = NUMER / a;
    return E_W'((b + 1) >> 1);
  endfunction

  logic [E_W-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign tbl[g] = rule(int'(ENTRIES + g));
  end

  assign est_o = tbl[idx_i];

  always_comb begin
    if (!$isunknown(idx_i)) begin
      p_est_range_r1: assert (est_o[E_W-1] == 1'b1)
        else $error("estimate outside 256..511");
    end
  end

endmodule

// File: rtl/recip_classify.sv
module recip_classify
  import recip_est_pkg::*;
(
  input  logic [WORD_W-1:0] op_i,
  input  logic [1:0]        rnd_i,
  input  logic              ftz_i,
  input  logic              dnan_i,
  output cls_t              cls_o
);

  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              e_zero, e_ones, f_zero;
  logic              is_nan, is_inf, is_zero, is_tiny, is_big;
  logic              to_inf;

  assign sgn    = op_i[WORD_W-1];
  assign ex     = op_i[WORD_W-2 -: EXP_W];
  assign fr     = op_i[FRAC_W-1:0];
  assign e_zero = (ex == '0);
  assign e_ones = (ex == EXP_W'(EXP_MAX));
  assign f_zero = (fr == '0);

  assign is_nan  = e_ones && !f_zero;
  assign is_inf  = e_ones && f_zero;
  assign is_zero = e_zero && (f_zero || ftz_i);
  assign is_tiny = e_zero && (fr[FRAC_W-1 -: 2] == 2'b00);
  assign is_big  = ftz_i && !e_ones && (ex >= EXP_W'(EXP_MAX - 2));

  always_comb begin
    case (rnd_i)
      2'd0:    to_inf = 1'b1;
      2'd1:    to_inf = !sgn;
      2'd2:    to_inf = sgn;
      default: to_inf = 1'b0;
    endcase
  end

  always_comb begin
    cls_o      = '0;
    cls_o.kind = RK_EST;
    cls_o.sign = sgn;
    if (is_nan) begin
      cls_o.kind          = dnan_i ? RK_DNAN : RK_QNAN;
      cls_o.flags[FL_INV] = !fr[FRAC_W-1];
    end else if (is_inf) begin
      cls_o.kind = RK_ZERO;
    end else if (is_zero) begin
      cls_o.kind         = RK_INF;
      cls_o.flags[FL_DZ] = 1'b1;
    end else if (is_tiny) begin
      cls_o.kind          = to_inf ? RK_INF : RK_MAXN;
      cls_o.flags[FL_OVF] = 1'b1;
      cls_o.flags[FL_INX] = 1'b1;
    end else if (is_big) begin
      cls_o.kind          = RK_ZERO;
      cls_o.flags[FL_UNF] = 1'b1;
    end else if (!e_zero) begin
      cls_o.xexp = $signed({2'b00, ex});
      cls_o.idx  = fr[FRAC_W-1 -: IDX_W];
    end else if (fr[FRAC_W-1]) begin
      cls_o.xexp = '0;
      cls_o.idx  = fr[FRAC_W-2 -: IDX_W];
    end else begin
      cls_o.xexp = -XEXP_W'(1);
      cls_o.idx  = fr[FRAC_W-3 -: IDX_W];
    end
  end

  always_comb begin
    if (!$isunknown(op_i) && !$isunknown(ftz_i)) begin
      p_inv_only_nan_r3: assert (!cls_o.flags[FL_INV] || is_nan)
        else $error("invalid raised for a non-NaN operand");
      p_one_class_r6: assert ($countones({is_nan, is_inf, e_zero && f_zero}) <= 1)
        else $error("operand in more than one class");
    end
  end

endmodule

// File: rtl/recip_pack.sv
module recip_pack
  import recip_est_pkg::*;
(
  input  cls_t              cls_i,
  input  logic [WORD_W-1:0] op_i,
  input  logic [EST_W-1:0]  est_i,
  output logic [WORD_W-1:0] res_o
);

  localparam logic signed [XEXP_W-1:0] RB = XEXP_W'(RBIAS);

  logic signed [XEXP_W-1:0] rexp;
  logic [FRAC_W-1:0]        frac_n, frac_0, frac_m1;

  assign rexp    = RB - cls_i.xexp;
  assign frac_n  = {est_i[IDX_W-1:0], {(FRAC_W-IDX_W){1'b0}}};
  assign frac_0  = {1'b1, frac_n[FRAC_W-1:1]};
  assign frac_m1 = {2'b01, frac_n[FRAC_W-1:2]};

  always_comb begin
    res_o = '0;
    case (cls_i.kind)
      RK_EST: begin
        if (rexp == '0) begin
          res_o = {cls_i.sign, {EXP_W{1'b0}}, frac_0};
        end else if (rexp == -XEXP_W'(1)) begin
          res_o = {cls_i.sign, {EXP_W{1'b0}}, frac_m1};
        end else begin
          res_o = {cls_i.sign, rexp[EXP_W-1:0], frac_n};
        end
      end
      RK_QNAN: res_o = op_i | (WORD_W'(1) << (FRAC_W - 1));
      RK_DNAN: res_o = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      RK_ZERO: res_o = {cls_i.sign, {(WORD_W-1){1'b0}}};
      RK_INF:  res_o = {cls_i.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      RK_MAXN: res_o = {cls_i.sign, EXP_W'(EXP_MAX - 1), {FRAC_W{1'b1}}};
      default: res_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(cls_i) && !$isunknown(est_i)) begin
      if (cls_i.kind == RK_EST) begin
        p_est_finite_r1: assert (res_o[WORD_W-2 -: EXP_W] != EXP_W'(EXP_MAX))
          else $error("estimate produced a non-finite word");
      end
      if (cls_i.kind == RK_QNAN) begin
        p_nan_quiet_r3: assert (res_o[FRAC_W-1] && res_o[WORD_W-2 -: EXP_W] == EXP_W'(EXP_MAX))
          else $error("NaN result not quiet");
      end
    end
  end

endmodule

// File: rtl/recip_est_unit.sv
module recip_est_unit
  import recip_est_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_op,
  input  logic [1:0]        rnd_mode,
  input  logic              ftz_en,
  input  logic              dnan_en,
  input  logic              flag_clr,
  output logic              out_valid,
  output logic [31:0]       out_res,
  output logic [4:0]        flag_sticky
);

  // reset synchroniser: asserts at once, releases after two edges
  logic rs_q1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rst_q <= rs_q1;
    end
  end

  assign in_ready = 1'b1;

  // stage 1: operand and controls
  logic              s1_vld, s1_vld_d;
  logic [WORD_W-1:0] s1_op, s1_op_d;
  logic [1:0]        s1_rnd, s1_rnd_d;
  logic              s1_ftz, s1_ftz_d;
  logic              s1_dn, s1_dn_d;
  logic              s1_en;

  assign s1_en = in_valid && in_ready;

  always_comb begin
    s1_vld_d = s1_en;
    s1_op_d  = s1_op;
    s1_rnd_d = s1_rnd;
    s1_ftz_d = s1_ftz;
    s1_dn_d  = s1_dn;
    if (s1_en) begin
      s1_op_d  = in_op;
      s1_rnd_d = rnd_mode;
      s1_ftz_d = ftz_en;
      s1_dn_d  = dnan_en;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_vld <= 1'b0;
      s1_op  <= '0;
      s1_rnd <= '0;
      s1_ftz <= 1'b0;
      s1_dn  <= 1'b0;
    end else begin
      s1_vld <= s1_vld_d;
      s1_op  <= s1_op_d;
      s1_rnd <= s1_rnd_d;
      s1_ftz <= s1_ftz_d;
      s1_dn  <= s1_dn_d;
    end
  end

  // datapath between the two stages
  cls_t              cls;
  logic [EST_W-1:0]  est;
  logic [WORD_W-1:0] res;

  recip_classify u_cls (
    .op_i   (s1_op),
    .rnd_i  (s1_rnd),
    .ftz_i  (s1_ftz),
    .dnan_i (s1_dn),
    .cls_o  (cls)
  );

  recip_est_rom #(.IDX_W(IDX_W)) u_rom (
    .idx_i (cls.idx),
    .est_o (est)
  );

  recip_pack u_pack (
    .cls_i (cls),
    .op_i  (s1_op),
    .est_i (est),
    .res_o (res)
  );

  // stage 2: result and sticky flags
  logic              ov_d;
  logic [WORD_W-1:0] or_d;
  logic [FLAG_W-1:0] fl_d;

  always_comb begin
    ov_d = s1_vld;
    or_d = out_res;
    fl_d = flag_clr ? '0 : flag_sticky;
    if (s1_vld) begin
      or_d = res;
      fl_d = fl_d | cls.flags;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid   <= 1'b0;
      out_res     <= '0;
      flag_sticky <= '0;
    end else begin
      out_valid   <= ov_d;
      out_res     <= or_d;
      flag_sticky <= fl_d;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |-> ##2 out_valid)
    else $error("result missing two cycles after accept");

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |-> ##2 !out_valid)
    else $error("result without an operand");

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_q)
    !s1_vld |=> $stable(out_res))
    else $error("result changed without a completion");

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_q)
    !flag_clr |=> ((flag_sticky & $past(flag_sticky)) == $past(flag_sticky)))
    else $error("sticky flag dropped");

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_clr && !s1_vld) |=> (flag_sticky == '0))
    else $error("flags not cleared");

  p_dz_inf_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (s1_vld && cls.flags[FL_DZ]) |=> (out_res[30:23] == 8'hff && out_res[22:0] == '0))
    else $error("divide-by-zero without infinity");

endmodule

// File: tb/recip_est_unit_tb.sv
module recip_est_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_op = '0;
  logic [1:0]  rnd_mode = '0;
  logic        ftz_en = 1'b0;
  logic        dnan_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic        out_valid;
  logic [31:0] out_res;
  logic [4:0]  flag_sticky;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  recip_est_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .rnd_mode(rnd_mode), .ftz_en(ftz_en), .dnan_en(dnan_en),
    .flag_clr(flag_clr), .out_valid(out_valid), .out_res(out_res),
    .flag_sticky(flag_sticky)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // independent model built from the requirement text
  function automatic void model(input logic [31:0] op, input logic [1:0] rm,
                                input bit fz, input bit dn,
                                output logic [31:0] r, output logic [4:0] fl);
    bit s;
    int e, f, ex, m, idx, est, re, fr;
    bit to_inf;
    s  = op[31];
    e  = int'(op[30:23]);
    f  = int'(op[22:0]);
    fl = '0;
    if (e == 255 && f != 0) begin
      fl[0] = (op[22] == 1'b0);
      r = dn ? 32'h7fc00000 : (op | 32'h00400000);
    end else if (e == 255) begin
      r = {s, 31'd0};
    end else if (e == 0 && (f == 0 || fz)) begin
      r = {s, 8'hff, 23'd0};
      fl[1] = 1'b1;
    end else if (e == 0 && f < (1 << 21)) begin
      fl[2] = 1'b1;
      fl[4] = 1'b1;
      to_inf = (rm == 2'd0) || (rm == 2'd1 && !s) || (rm == 2'd2 && s);
      r = to_inf ? {s, 8'hff, 23'd0} : {s, 31'h7f7fffff};
    end else if (fz && e >= 253) begin
      r = {s, 31'd0};
      fl[3] = 1'b1;
    end else begin
      ex = e;
      m  = f;
      if (e == 0) begin
        if (f >= (1 << 22)) begin
          ex = 0;
          m  = (f << 1) & 32'h7fffff;
        end else begin
          ex = -1;
          m  = (f << 2) & 32'h7fffff;
        end
      end
      idx = 256 + (m >> 15);
      est = ((524288 / (2 * idx + 1)) + 1) / 2;
      re  = 253 - ex;
      fr  = (est & 255) << 15;
      if (re == 0) begin
        fr = (1 << 22) | (fr >> 1);
      end else if (re == -1) begin
        fr = (1 << 21) | (fr >> 2);
        re = 0;
      end
      r = {s, re[7:0], fr[22:0]};
    end
  endfunction

  task automatic clear_flags();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  // one operand, flags cleared first; checks latency, result and flags
  task automatic run_op(input string tag, input logic [31:0] op, input logic [1:0] rm,
                        input bit fz, input bit dn, output logic [31:0] got);
    logic [31:0] er;
    logic [4:0]  ef;
    model(op, rm, fz, dn, er, ef);
    clear_flags();
    @(negedge clk);
    in_op = op; rnd_mode = rm; ftz_en = fz; dnan_en = dn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R2 early"}, {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk({tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " result"}, out_res, er);
    chk({tag, " flags R10"}, {27'd0, flag_sticky}, {27'd0, ef});
    got = out_res;
  endtask

  task automatic t_reset();
    chk("R11 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R11 flags in reset", {27'd0, flag_sticky}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R11 result after reset", out_res, 32'd0);
    chk("R11 flags after reset", {27'd0, flag_sticky}, 32'd0);
    chk("R2 ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_normal();
    logic [31:0] g;
    run_op("R1 one", 32'h3f800000, 2'd0, 1'b0, 1'b0, g);
    chk("R1 one const", g, 32'h3f7f8000);
    run_op("R1 three", 32'h40400000, 2'd0, 1'b0, 1'b0, g);
    run_op("R1 neg frac", 32'hbf9a3c00, 2'd3, 1'b0, 1'b0, g);
    run_op("R1 big mant", 32'h42fff000, 2'd1, 1'b1, 1'b0, g);
    run_op("R1 small exp", 32'h00812345, 2'd0, 1'b0, 1'b0, g);
  endtask

  task automatic t_nan();
    logic [31:0] g;
    run_op("R3 qnan", 32'h7fc12345, 2'd0, 1'b0, 1'b0, g);
    run_op("R3 snan", 32'hff812345, 2'd0, 1'b0, 1'b0, g);
    chk("R3 snan const", g, 32'hffc12345);
    run_op("R3 dnan", 32'h7f800001, 2'd0, 1'b0, 1'b1, g);
    chk("R3 dnan const", g, 32'h7fc00000);
  endtask

  task automatic t_inf_zero();
    logic [31:0] g;
    run_op("R4 +inf", 32'h7f800000, 2'd0, 1'b0, 1'b0, g);
    run_op("R4 -inf", 32'hff800000, 2'd0, 1'b0, 1'b0, g);
    chk("R4 -inf const", g, 32'h80000000);
    run_op("R5 +zero", 32'h00000000, 2'd0, 1'b0, 1'b0, g);
    run_op("R5 -zero", 32'h80000000, 2'd2, 1'b0, 1'b0, g);
    chk("R5 -zero const", g, 32'hff800000);
  endtask

  task automatic t_tiny();
    logic [31:0] g;
    for (int m = 0; m < 4; m++) begin
      run_op($sformatf("R6 pos mode%0d", m), 32'h00012345, 2'(m), 1'b0, 1'b0, g);
      run_op($sformatf("R6 neg mode%0d", m), 32'h801fffff, 2'(m), 1'b0, 1'b0, g);
    end
    run_op("R6 mode3 const", 32'h00000001, 2'd3, 1'b0, 1'b0, g);
    chk("R6 maxnorm const", g, 32'h7f7fffff);
  endtask

  task automatic t_large();
    logic [31:0] g;
    run_op("R7 e253 ftz", 32'h7e800000, 2'd0, 1'b1, 1'b0, g);
    run_op("R7 e254 ftz neg", 32'hff7fffff, 2'd0, 1'b1, 1'b0, g);
    run_op("R7 e253 sub", 32'h7e800000, 2'd0, 1'b0, 1'b0, g);
    chk("R7 e253 const", g, 32'h007fc000);
    run_op("R7 e254 sub", 32'h7f000000, 2'd0, 1'b0, 1'b0, g);
    chk("R7 e254 const", g, 32'h003fe000);
  endtask

  task automatic t_subnormal();
    logic [31:0] g;
    run_op("R8 top set", 32'h00600000, 2'd0, 1'b0, 1'b0, g);
    run_op("R8 top clear", 32'h00300000, 2'd0, 1'b0, 1'b0, g);
    run_op("R8 neg mixed", 32'h805abcde, 2'd0, 1'b0, 1'b0, g);
    run_op("R9 flushed", 32'h00600000, 2'd0, 1'b1, 1'b0, g);
    chk("R9 flushed const", g, 32'h7f800000);
    run_op("R9 flushed neg", 32'h80000001, 2'd3, 1'b1, 1'b0, g);
  endtask

  task automatic t_sticky();
    clear_flags();
    @(negedge clk);
    in_op = 32'h00000000; ftz_en = 1'b0; dnan_en = 1'b0; rnd_mode = 2'd0; in_valid = 1'b1;
    @(negedge clk);
    in_op = 32'h7f800005;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 first flag", {27'd0, flag_sticky}, 32'h02);
    @(negedge clk);
    chk("R10 accumulated", {27'd0, flag_sticky}, 32'h03);
    repeat (3) @(negedge clk);
    chk("R10 held", {27'd0, flag_sticky}, 32'h03);
    clear_flags();
    chk("R10 cleared", {27'd0, flag_sticky}, 32'h00);
  endtask

  task automatic t_stream();
    logic [31:0] ops [4];
    logic [31:0] er  [4];
    logic [4:0]  ef;
    ops[0] = 32'h3f800000; ops[1] = 32'hc1200000;
    ops[2] = 32'h3e4ccccd; ops[3] = 32'h7f800000;
    for (int i = 0; i < 4; i++) model(ops[i], 2'd0, 1'b0, 1'b0, er[i], ef);
    clear_flags();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk($sformatf("R2 stream valid %0d", i - 2), {31'd0, out_valid}, 32'd1);
        chk($sformatf("R2 stream result %0d", i - 2), out_res, er[i-2]);
      end
      if (i < 4) begin
        in_op = ops[i]; rnd_mode = 2'd0; ftz_en = 1'b0; dnan_en = 1'b0; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R2 stream end", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal();
    t_nan();
    t_inf_zero();
    t_tiny();
    t_large();
    t_subnormal();
    t_sticky();
    t_stream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule